// File: doc/BRIEF.md
# SECDED Self-Test Injection Controller

This block sits in front of a 64-bit SECDED checker on a flash read path. It lets software test that checker while the system runs. Software loads a test address, a 64-bit test word and an 8-bit test check byte into the block's registers. While test mode is on, the checker takes its input from these registers and not from the flash array. Any flash read issued in that time is answered with the checked test word, and the flash data is not used.

There are two ways to run a test. In continuous mode the checker evaluates the test registers on every clock, so an injected error keeps the correctable-error interrupt or the uncorrectable-error fault raised until software turns test mode off. In one-shot mode a calculate bit runs the evaluation for exactly one cycle, which gives a single pulse on those lines. Test evaluations run whether or not the normal check enable is set. The interrupt and fault lines are the same ones that normal checked reads drive. The syndrome, the error class and the corrected word of the latest test evaluation are held in result registers that software can read.

A three-state machine selects the checker's input source:
- ST_IDLE: normal checked flash path.
- ST_SHOT: one-shot test evaluation.
- ST_CONT: continuous test mode.

A control write sets the next state. If the test-enable bit is set, the next state is ST_CONT. If only the calculate bit is set, it is ST_SHOT. If neither bit is set, it is ST_IDLE. With no control write, ST_SHOT always returns to ST_IDLE after its one cycle, and ST_IDLE and ST_CONT hold.

Top module: `sdt_inject_ctrl`

## Requirements
- R1: Check code. Data bit i sits at the (i+1)-th integer that is 3 or larger and not a power of two, so bit 0 is at 3, bit 1 at 5, bit 2 at 6 and bit 5 at 10.
  - Check bit k (k = 0..6) is the XOR of the data bits whose position has bit k set.
  - Check bit 7 makes the parity of all 72 bits even.
  - On a flash read with the check enable high, rd_data carries the word with any single data-bit error corrected.
- R2: Error classes.
  - The syndrome byte is {overall parity, 7-bit recomputed-XOR-stored check}.
  - Class 0 (no error): parity 0 and syndrome 0.
  - Class 1 (correctable): parity 1 and a 7-bit syndrome of 71 or less. A syndrome of 0 or a power of two marks a check-bit error, and the data is returned unchanged.
  - Class 2 (uncorrectable): parity 0 with a nonzero syndrome, or parity 1 with a syndrome above 71. The data is returned uncorrected.
- R3: A 72-bit word that is all ones or all zeros is class 0 and is passed through unchanged.
- R4: With the check enable low and test mode off, a flash read returns the raw flash word and raises neither corr_irq nor fault.
- R5: In ST_CONT the test registers are evaluated on every cycle.
  - corr_irq and fault follow that result on every cycle until test mode is cleared.
  - A flash read returns the checked test word on rd_data and the test address on rd_addr.
- R6: Writing the calculate bit (control bit 1) evaluates the test registers for exactly one cycle, so an enabled single-bit error gives a corr_irq pulse one cycle wide.
  - The calculate bit always reads back as 0.
  - A flash read during that cycle returns raw flash data.
- R7: Test evaluations (ST_SHOT and ST_CONT) take place regardless of the check enable.
- R8: corr_irq is raised only when control bit 2 is set, and fault only when control bit 3 is set. The two are never high together.
- R9: Result registers.
  - The syndrome byte (read bits 7:0), the class (read bits 9:8) and the corrected word are updated only by test evaluations. Checked flash reads leave them unchanged.
  - For a data bit 5 error the syndrome-and-class read value is 0x18A.
- R10: Writes to the test address, data and check registers are ignored in any cycle in which a test evaluation runs (ST_SHOT or ST_CONT). They take effect when no test evaluation is running.
- R11: After reset all registers, results and outputs are 0 and the state is ST_IDLE.
- R12: reg_rdata shows the register selected by reg_sel in the same cycle, with this map:
  - 0: test address
  - 1: test data low
  - 2: test data high
  - 3: test check
  - 4: control {fault enable bit 3, interrupt enable bit 2, 0 at bit 1, test-enable status bit 0}
  - 5: syndrome and class
  - 6: result low
  - 7: result high
- R13: rd_valid, rd_data, rd_addr, corr_irq and fault are registered. They reflect the inputs and state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| chk_en | input | 1 | Normal read-path check enable |
| fl_rd_req | input | 1 | Flash read request, data valid in the same cycle |
| fl_addr | input | ADDR_W | Flash read address |
| fl_data | input | 64 | Flash word |
| fl_ecc | input | 8 | Flash check byte |
| rd_valid | output | 1 | Read response valid |
| rd_addr | output | ADDR_W | Address that was checked |
| rd_data | output | 64 | Read response word |
| corr_irq | output | 1 | Correctable-error interrupt |
| fault | output | 1 | Uncorrectable-error fault |

## Verification
The main function is tried with clean code words, a flipped data bit, a flipped check bit, two flipped data bits, a check pattern whose syndrome lies beyond the last code position, and the all-ones and all-zeros words. Together these separate correction, check-bit tolerance, double detection, out-of-range detection and the skip rule. The same error words are sent through one-shot and continuous test mode with the check enable low. This shows that a one-shot gives a single pulse while continuous mode holds the line, and that test evaluation does not depend on the enable. Writes issued during continuous mode, followed by reads of the test registers, show whether the lock holds. Normal reads followed by reads of the result registers show that those reads do not update them.

// File: rtl/sdt_pkg.sv
`timescale 1ns/1ps
package sdt_pkg;
    localparam int DATA_W   = 64;
    localparam int CHK_W    = 8;
    localparam int SYN_W    = CHK_W - 1;
    localparam int REG_W    = DATA_W / 2;
    localparam int SEL_W    = 3;
    localparam int LAST_POS = DATA_W + SYN_W;

    localparam logic [SEL_W-1:0] SEL_TADDR = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TLO   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_THI   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_TCHK  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_RSYN  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_RLO   = 3'd6;
    localparam logic [SEL_W-1:0] SEL_RHI   = 3'd7;

    localparam int CTRL_TEST  = 0;
    localparam int CTRL_SHOT  = 1;
    localparam int CTRL_IRQ   = 2;
    localparam int CTRL_FAULT = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SHOT = 2'd1,
        ST_CONT = 2'd2
    } sdt_state_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_CORR  = 2'd1,
        ERR_UNCOR = 2'd2
    } sdt_err_e;

    // Code position of data bit idx: idx-th non-power-of-two value from 3 up.
    function automatic logic [SYN_W-1:0] data_pos(input int idx);
        int cnt;
        logic [SYN_W-1:0] res;
        cnt = 0;
        res = '0;
        for (int p = 3; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx) res = SYN_W'(p);
                cnt++;
            end
        end
        return res;
    endfunction

    // Data bits that contribute to check bit k.
    function automatic logic [DATA_W-1:0] col_mask(input int k);
        logic [DATA_W-1:0] m;
        logic [SYN_W-1:0]  p;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            p    = data_pos(i);
            m[i] = p[k];
        end
        return m;
    endfunction
endpackage

// File: rtl/sdt_secded.sv
`timescale 1ns/1ps
module sdt_secded
    import sdt_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [CHK_W-1:0]  syn_o,
    output sdt_err_e          err_o,
    output logic [DATA_W-1:0] data_o
);
    logic [SYN_W-1:0]  syn;
    logic [DATA_W-1:0] hit;
    logic              par;
    logic              skip;

    for (genvar k = 0; k < SYN_W; k++) begin : g_syn
        assign syn[k] = ^(data_i & col_mask(k)) ^ chk_i[k];
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        assign hit[i] = (syn == data_pos(i));
    end

    assign par  = ^{data_i, chk_i};
    assign skip = (&{data_i, chk_i}) | ~(|{data_i, chk_i});

    always_comb begin
        if (skip) begin
            err_o = ERR_NONE;
        end else if (!par) begin
            err_o = (syn == '0) ? ERR_NONE : ERR_UNCOR;
        end else begin
            err_o = (syn <= SYN_W'(LAST_POS)) ? ERR_CORR : ERR_UNCOR;
        end
    end

    assign data_o = (err_o == ERR_CORR) ? (data_i ^ hit) : data_i;
    assign syn_o  = {par, syn};
endmodule

// File: rtl/sdt_regs.sv
`timescale 1ns/1ps
module sdt_regs
    import sdt_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              lock_i,
    output logic [ADDR_W-1:0] taddr_o,
    output logic [DATA_W-1:0] tdata_o,
    output logic [CHK_W-1:0]  tchk_o,
    output logic              irq_en_o,
    output logic              fault_en_o
);
    logic test_we;
    logic ctrl_we;

    assign test_we = wr_en && !lock_i;
    assign ctrl_we = wr_en && (wr_sel == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taddr_o    <= '0;
            tdata_o    <= '0;
            tchk_o     <= '0;
            irq_en_o   <= 1'b0;
            fault_en_o <= 1'b0;
        end else begin
            if (test_we) begin
                case (wr_sel)
                    SEL_TADDR: taddr_o                  <= wr_data[ADDR_W-1:0];
                    SEL_TLO:   tdata_o[REG_W-1:0]       <= wr_data;
                    SEL_THI:   tdata_o[DATA_W-1:REG_W]  <= wr_data;
                    SEL_TCHK:  tchk_o                   <= wr_data[CHK_W-1:0];
                    default:   ;
                endcase
            end
            if (ctrl_we) begin
                irq_en_o   <= wr_data[CTRL_IRQ];
                fault_en_o <= wr_data[CTRL_FAULT];
            end
        end
    end
endmodule

// File: rtl/sdt_fsm.sv
`timescale 1ns/1ps
module sdt_fsm
    import sdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_we,
    input  logic want_cont,
    input  logic want_shot,
    output logic test_on,
    output logic shot_on
);
    sdt_state_e state_q;
    sdt_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            if (want_cont)      state_d = ST_CONT;
            else if (want_shot) state_d = ST_SHOT;
            else                state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SHOT: state_d = ST_IDLE;
                ST_CONT: state_d = ST_CONT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        test_on = 1'b0;
        shot_on = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHOT: shot_on = 1'b1;
            ST_CONT: test_on = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sdt_inject_ctrl.sv
`timescale 1ns/1ps
module sdt_inject_ctrl
    import sdt_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              chk_en,
    input  logic              fl_rd_req,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [63:0]       fl_data,
    input  logic [7:0]        fl_ecc,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic              corr_irq,
    output logic              fault
);
    logic              ctrl_we;
    logic              test_on;
    logic              shot_on;
    logic              eval_test;
    logic              eval_any;
    logic [ADDR_W-1:0] taddr;
    logic [DATA_W-1:0] tdata;
    logic [CHK_W-1:0]  tchk;
    logic              irq_en;
    logic              fault_en;
    logic [DATA_W-1:0] src_data;
    logic [CHK_W-1:0]  src_chk;
    logic [CHK_W-1:0]  dec_syn;
    sdt_err_e          dec_err;
    logic [DATA_W-1:0] dec_corr;
    logic              dec_single;
    logic              dec_double;
    logic [CHK_W-1:0]  res_syn;
    sdt_err_e          res_err;
    logic [DATA_W-1:0] res_data;

    assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);

    sdt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .want_cont (reg_wdata[CTRL_TEST]),
        .want_shot (reg_wdata[CTRL_SHOT]),
        .test_on   (test_on),
        .shot_on   (shot_on)
    );

    assign eval_test = test_on | shot_on;

    sdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_we),
        .wr_sel     (reg_sel),
        .wr_data    (reg_wdata),
        .lock_i     (eval_test),
        .taddr_o    (taddr),
        .tdata_o    (tdata),
        .tchk_o     (tchk),
        .irq_en_o   (irq_en),
        .fault_en_o (fault_en)
    );

    assign src_data = eval_test ? tdata : fl_data;
    assign src_chk  = eval_test ? tchk  : fl_ecc;

    sdt_secded u_dec (
        .data_i (src_data),
        .chk_i  (src_chk),
        .syn_o  (dec_syn),
        .err_o  (dec_err),
        .data_o (dec_corr)
    );

    assign dec_single = (dec_err == ERR_CORR);
    assign dec_double = (dec_err == ERR_UNCOR);
    assign eval_any   = eval_test | (fl_rd_req & chk_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_addr  <= '0;
            rd_data  <= '0;
            corr_irq <= 1'b0;
            fault    <= 1'b0;
            res_syn  <= '0;
            res_err  <= ERR_NONE;
            res_data <= '0;
        end else begin
            rd_valid <= fl_rd_req;
            if (fl_rd_req) begin
                rd_addr <= test_on ? taddr : fl_addr;
                rd_data <= (test_on || (!shot_on && chk_en)) ? dec_corr : fl_data;
            end
            corr_irq <= eval_any & dec_single & irq_en;
            fault    <= eval_any & dec_double & fault_en;
            if (eval_test) begin
                res_syn  <= dec_syn;
                res_err  <= dec_err;
                res_data <= dec_corr;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_TADDR: reg_rdata = REG_W'(taddr);
            SEL_TLO:   reg_rdata = tdata[REG_W-1:0];
            SEL_THI:   reg_rdata = tdata[DATA_W-1:REG_W];
            SEL_TCHK:  reg_rdata = REG_W'(tchk);
            SEL_CTRL: begin
                reg_rdata[CTRL_TEST]  = test_on;
                reg_rdata[CTRL_IRQ]   = irq_en;
                reg_rdata[CTRL_FAULT] = fault_en;
            end
            SEL_RSYN: begin
                reg_rdata[CHK_W-1:0]     = res_syn;
                reg_rdata[CHK_W+1:CHK_W] = res_err;
            end
            SEL_RLO:   reg_rdata = res_data[REG_W-1:0];
            SEL_RHI:   reg_rdata = res_data[DATA_W-1:REG_W];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdt_inject_chk.sv
`timescale 1ns/1ps
module sdt_inject_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_on,
    input logic              shot_on,
    input logic              dec_single,
    input logic              dec_double,
    input logic              irq_en,
    input logic              fault_en,
    input logic              chk_en,
    input logic              corr_irq,
    input logic              fault,
    input logic              fl_rd_req,
    input logic              rd_valid,
    input logic [63:0]       rd_data,
    input logic [63:0]       dec_corr,
    input logic              ctrl_we,
    input logic [ADDR_W-1:0] taddr,
    input logic [63:0]       tdata,
    input logic [7:0]        tchk
);
    AST_CONT_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && dec_single && irq_en) |=> corr_irq); // R5

    AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on && fl_rd_req) |=> (rd_valid && rd_data == $past(dec_corr))); // R5

    AST_SHOT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_on && !ctrl_we) |=> !shot_on); // R6

    AST_TEST_IGNORES_CHKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((test_on || shot_on) && dec_double && fault_en && !chk_en) |=> fault); // R7

    AST_IRQ_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(corr_irq && fault)); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_on && !shot_on && !chk_en) |=> (!corr_irq && !fault)); // R4

    AST_TEST_REGS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (test_on || shot_on) |=> ($stable(tdata) && $stable(tchk) && $stable(taddr))); // R10
endmodule

bind sdt_inject_ctrl sdt_inject_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_on    (test_on),
    .shot_on    (shot_on),
    .dec_single (dec_single),
    .dec_double (dec_double),
    .irq_en     (irq_en),
    .fault_en   (fault_en),
    .chk_en     (chk_en),
    .corr_irq   (corr_irq),
    .fault      (fault),
    .fl_rd_req  (fl_rd_req),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .dec_corr   (dec_corr),
    .ctrl_we    (ctrl_we),
    .taddr      (taddr),
    .tdata      (tdata),
    .tchk       (tchk)
);

// File: tb/sdt_inject_ctrl_tb.sv
`timescale 1ns/1ps
module sdt_inject_ctrl_tb;
    localparam int ADDR_W = 20;

    logic              clk;
    logic              rst_n;
    logic              reg_we;
    logic [2:0]        reg_sel;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              chk_en;
    logic              fl_rd_req;
    logic [ADDR_W-1:0] fl_addr;
    logic [63:0]       fl_data;
    logic [7:0]        fl_ecc;
    logic              rd_valid;
    logic [ADDR_W-1:0] rd_addr;
    logic [63:0]       rd_data;
    logic              corr_irq;
    logic              fault;

    sdt_inject_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chk_en(chk_en),
        .fl_rd_req(fl_rd_req), .fl_addr(fl_addr), .fl_data(fl_data),
        .fl_ecc(fl_ecc), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_data(rd_data), .corr_irq(corr_irq), .fault(fault)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int pos_tab [64];

    // ---------------- behavioural reference ----------------
    int          m_mode;      // 0 normal, 1 one-shot, 2 continuous
    logic [19:0] m_taddr;
    logic [63:0] m_tdata;
    logic [7:0]  m_tchk;
    bit          m_irq_en, m_fault_en;
    logic [7:0]  m_res_syn;
    logic [1:0]  m_res_err;
    logic [63:0] m_res_data;
    bit          e_rd_valid, e_irq, e_fault;
    logic [63:0] e_rd_data;
    logic [19:0] e_rd_addr;

    initial begin
        int v, n;
        v = 2;
        for (int i = 0; i < 64; i++) begin
            v++;
            while ($countones(v) == 1) v++;
            pos_tab[i] = v;
        end
        n = 0;
    end

    function automatic logic [7:0] ref_enc(input logic [63:0] d);
        int s;
        logic [7:0] e;
        s = 0;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ pos_tab[i];
        e[6:0] = s[6:0];
        e[7]   = (($countones(d) + $countones(s[6:0])) % 2) == 1;
        return e;
    endfunction

    task automatic ref_dec(input logic [63:0] d, input logic [7:0] e,
                           output logic [7:0] syn, output logic [1:0] err,
                           output logic [63:0] corr);
        int s;
        bit par;
        s = 0;
        for (int i = 0; i < 64; i++) if (d[i]) s = s ^ pos_tab[i];
        for (int k = 0; k < 7; k++) if (e[k]) s = s ^ (1 << k);
        par = (($countones(d) + $countones(e)) % 2) == 1;
        syn = {par, s[6:0]};
        if ((d == '1 && e == '1) || (d == '0 && e == '0)) err = 2'd0;
        else if (!par) err = (s == 0) ? 2'd0 : 2'd2;
        else if (s > 71) err = 2'd2;
        else err = 2'd1;
        corr = d;
        if (err == 2'd1)
            for (int i = 0; i < 64; i++) if (pos_tab[i] == s) corr[i] = ~corr[i];
    endtask

    always @(posedge clk) begin
        logic [63:0] sd, corr;
        logic [7:0]  se, syn;
        logic [1:0]  err;
        bit          evt, evf;
        if (!rst_n) begin
            m_mode = 0; m_taddr = '0; m_tdata = '0; m_tchk = '0;
            m_irq_en = 0; m_fault_en = 0;
            m_res_syn = '0; m_res_err = '0; m_res_data = '0;
            e_rd_valid = 0; e_irq = 0; e_fault = 0; e_rd_data = '0; e_rd_addr = '0;
        end else begin
            evt = (m_mode != 0);
            sd  = evt ? m_tdata : fl_data;
            se  = evt ? m_tchk  : fl_ecc;
            ref_dec(sd, se, syn, err, corr);
            evf = !evt && fl_rd_req && chk_en;
            e_irq   = (evt || evf) && err == 2'd1 && m_irq_en;
            e_fault = (evt || evf) && err == 2'd2 && m_fault_en;
            e_rd_valid = fl_rd_req;
            if (fl_rd_req) begin
                e_rd_addr = (m_mode == 2) ? m_taddr : fl_addr;
                e_rd_data = (m_mode == 2 || evf) ? corr : fl_data;
            end
            if (evt) begin
                m_res_syn = syn; m_res_err = err; m_res_data = corr;
            end
            if (reg_we && reg_sel == 3'd4) begin
                m_irq_en   = reg_wdata[2];
                m_fault_en = reg_wdata[3];
                m_mode = reg_wdata[0] ? 2 : (reg_wdata[1] ? 1 : 0);
            end else begin
                if (reg_we && !evt) begin
                    case (reg_sel)
                        3'd0: m_taddr = reg_wdata[19:0];
                        3'd1: m_tdata[31:0] = reg_wdata;
                        3'd2: m_tdata[63:32] = reg_wdata;
                        3'd3: m_tchk = reg_wdata[7:0];
                        default: ;
                    endcase
                end
                if (m_mode == 1) m_mode = 0;
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (reg_sel)
            3'd0: return {12'b0, m_taddr};
            3'd1: return m_tdata[31:0];
            3'd2: return m_tdata[63:32];
            3'd3: return {24'b0, m_tchk};
            3'd4: return {28'b0, m_fault_en, m_irq_en, 1'b0, (m_mode == 2)};
            3'd5: return {22'b0, m_res_err, m_res_syn};
            3'd6: return m_res_data[31:0];
            default: return m_res_data[63:32];
        endcase
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R13 rd_valid", 64'(rd_valid), 64'(e_rd_valid));
        if (e_rd_valid) begin
            chk("R1 rd_data vs model", rd_data, e_rd_data);
            chk("R5 rd_addr vs model", 64'(rd_addr), 64'(e_rd_addr));
        end
        chk("R8 corr_irq vs model", 64'(corr_irq), 64'(e_irq));
        chk("R8 fault vs model", 64'(fault), 64'(e_fault));
        chk("R12 reg_rdata vs model", 64'(reg_rdata), 64'(exp_rdata()));
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (rst_n) compare_all();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd_flash(input logic [19:0] a, input logic [63:0] d, input logic [7:0] e);
        fl_rd_req = 1'b1; fl_addr = a; fl_data = d; fl_ecc = e;
        step();
        fl_rd_req = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] D, T;
        logic [7:0]  E, TE;
        rst_n = 1'b0; reg_we = 1'b0; reg_sel = 3'd4; reg_wdata = '0;
        chk_en = 1'b0; fl_rd_req = 1'b0; fl_addr = '0; fl_data = '0; fl_ecc = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        D  = 64'h0123_4567_89AB_CDEF;
        E  = ref_enc(D);
        T  = 64'hFEDC_BA98_7654_3210;
        TE = ref_enc(T);

        step();
        chk("R11 control after reset", 64'(reg_rdata), 64'h0);
        chk("R11 corr_irq after reset", 64'(corr_irq), 64'h0);
        chk("R11 fault after reset", 64'(fault), 64'h0);
        chk("R11 rd_valid after reset", 64'(rd_valid), 64'h0);

        wr(3'd4, 32'hC);
        chk_en = 1'b1;
        rd_flash(20'h00010, D ^ (64'h1 << 5), E);
        chk("R1 single data bit corrected", rd_data, D);
        chk("R1 irq on correction", 64'(corr_irq), 64'h1);
        rd_flash(20'h00011, D, E ^ 8'h08);
        chk("R2 check-bit error data unchanged", rd_data, D);
        chk("R2 check-bit error irq", 64'(corr_irq), 64'h1);
        rd_flash(20'h00012, D ^ 64'h3, E);
        chk("R2 double error fault", 64'(fault), 64'h1);
        chk("R2 double error no irq", 64'(corr_irq), 64'h0);
        rd_flash(20'h00013, D, E ^ 8'h7F);
        chk("R2 syndrome beyond last position", 64'(fault), 64'h1);
        rd_flash(20'h00014, '1, '1);
        chk("R3 all ones skipped", 64'(corr_irq | fault), 64'h0);
        chk("R3 all ones data", rd_data, '1);
        rd_flash(20'h00015, '0, '0);
        chk("R3 all zeros skipped", 64'(corr_irq | fault), 64'h0);
        rd_flash(20'h00016, D, E);
        chk("R1 clean word", rd_data, D);

        chk_en = 1'b0;
        rd_flash(20'h00017, D ^ (64'h1 << 5), E);
        chk("R4 raw data when disabled", rd_data, D ^ (64'h1 << 5));
        chk("R4 no irq when disabled", 64'(corr_irq), 64'h0);
        chk_en = 1'b1;
        wr(3'd4, 32'h0);
        rd_flash(20'h00018, D ^ 64'h3, E);
        chk("R8 fault masked", 64'(fault), 64'h0);
        rd_flash(20'h00019, D ^ (64'h1 << 5), E);
        chk("R8 irq masked", 64'(corr_irq), 64'h0);
        reg_sel = 3'd5;
        step();
        chk("R9 results untouched by flash reads", 64'(reg_rdata), 64'h0);

        // one-shot evaluation of a bit-5 error
        wr(3'd0, 32'h5A5A5);
        wr(3'd1, T[31:0] ^ 32'h20);
        wr(3'd2, T[63:32]);
        wr(3'd3, {24'b0, TE});
        wr(3'd4, 32'hE);
        chk("R6 no pulse before evaluation", 64'(corr_irq), 64'h0);
        step();
        chk("R6 pulse after one-shot", 64'(corr_irq), 64'h1);
        step();
        chk("R6 pulse lasts one cycle", 64'(corr_irq), 64'h0);
        reg_sel = 3'd4;
        step();
        chk("R6 calculate bit reads zero", 64'(reg_rdata), 64'hC);
        reg_sel = 3'd5;
        step();
        chk("R9 syndrome and class", 64'(reg_rdata), 64'h18A);
        reg_sel = 3'd6;
        step();
        chk("R9 corrected word low", 64'(reg_rdata), 64'(T[31:0]));

        // continuous evaluation of a double error with checking disabled
        chk_en = 1'b0;
        wr(3'd1, T[31:0] ^ 32'h3);
        wr(3'd4, 32'hD);
        step();
        chk("R7 fault with check disabled", 64'(fault), 64'h1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R5 fault held in continuous mode", 64'(fault), 64'h1);
        end
        rd_flash(20'h00111, D, E);
        chk("R5 bypass data", rd_data, T ^ 64'h3);
        chk("R5 bypass address", 64'(rd_addr), 64'h5A5A5);
        wr(3'd1, 32'hDEAD_BEEF);
        reg_sel = 3'd1;
        step();
        chk("R10 write ignored during test", 64'(reg_rdata), 64'(T[31:0] ^ 32'h3));
        reg_sel = 3'd4;
        step();
        chk("R12 test enable status", 64'(reg_rdata), 64'hD);
        wr(3'd4, 32'hC);
        step();
        chk("R5 fault drops after clear", 64'(fault), 64'h0);
        wr(3'd1, 32'h1234_5678);
        reg_sel = 3'd1;
        step();
        chk("R10 write accepted when idle", 64'(reg_rdata), 64'h1234_5678);

        // one-shot with the check enable low, single error reaches irq
        wr(3'd1, T[31:0] ^ 32'h1);
        wr(3'd1, T[31:0] ^ 32'h1);
        wr(3'd4, 32'h6);
        step();
        chk("R7 one-shot with check disabled", 64'(corr_irq), 64'h1);
        repeat (3) step();

        done = 1;
        summary();
        $finish;
    end
endmodule